// File: doc/BRIEF.md
# Guarded Pin Configuration Register Bank

This block holds the configuration of a bank of I/O pins behind a simple 32-bit register read/write bus. For every pin it stores a mode bit (GPIO or peripheral), a 4-bit function number, a drive-strength code, a pull enable, a pull direction and an I/O voltage selection. It turns these into per-pin control buses for the pad ring: peripheral enable, function number, drive current in mA, pull-up, pull-down and 3.3 V select.

The mode, function, drive and voltage registers are guarded. A write to one of them lands only if the bus write just before it put the bitwise complement of the same data into the unlock register at offset 0x000. Any other access in between disarms the guard. A guarded write that arrives unarmed is dropped and sets a sticky error flag. The pull registers and the status register are written directly.

Top module: `pinmux_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads zero. All pins are GPIO, the function output is 0, both pulls are off and 3.3 V select is 0. The error flag is 0. Drive outputs show the lowest code: 3 mA on 3-bit pins and 6 mA on 2-bit pins.
- R2: Mode registers sit at 0x100 + 4*k and hold one bit per pin, for pins 32k to 32k+31. A 1 sets `pin_periph` high for that pin, a 0 selects GPIO. With no bus write, `pin_periph` does not change.
- R3: A write to a guarded register (mode, function, drive, voltage) without a valid unlock leaves the register unchanged. It sets `lock_err`, and `lock_err` stays set until it is cleared.
- R4: An unlock write whose data is not the bitwise complement of the following guarded write's data does not allow that write.
- R5: Any bus access other than an unlock write disarms the guard, whether it is a read or a write to another register. The guarded write that follows is then dropped.
- R6: Function registers sit at 0x200 + 4*(p/8). Pin p uses bits [4*(p%8)+3 : 4*(p%8)]. `pin_func` for a pin shows the field while the pin is in peripheral mode and shows 0 in GPIO mode.
- R7: Drive registers sit at 0x300 + 4*(p/8), with a 4-bit slot per pin at the same shift as R6. Even pins keep 3 code bits and odd pins keep 2. Unused slot bits are discarded and read 0. `pin_drv_ma` = (code+1)*3 for 3-bit pins and (code+1)*6 for 2-bit pins, 5 bits per pin.
- R8: Pull enable sits at 0x400 + 4*k and pull direction at 0x500 + 4*k, one bit per pin, written without unlock. `pin_pull_up` = enable AND direction. `pin_pull_dn` = enable AND NOT direction.
- R9: Voltage registers sit at 0x600 + 4*k, one bit per pin, and are guarded. A 1 drives `pin_v33` high (3.3 V) and a 0 selects 1.8 V.
- R10: Read data appears on `bus_rdata` one cycle after the read request. Unmapped offsets return 0, and writes to them change nothing and do not set `lock_err`.
- R11: Status at 0x700 reads the error flag in bit 0, and any write to it clears the flag. A read of the unlock register returns 0.
- R12: One unlock allows exactly one guarded write. A second guarded write straight after it is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| lock_err | output | 1 | Sticky flag for a dropped guarded write |
| pin_periph | output | NUM_PINS | Peripheral mode per pin |
| pin_func | output | 4*NUM_PINS | Function number per pin, 0 in GPIO mode |
| pin_drv_ma | output | 5*NUM_PINS | Drive current in mA per pin |
| pin_pull_up | output | NUM_PINS | Pull-up active |
| pin_pull_dn | output | NUM_PINS | Pull-down active |
| pin_v33 | output | NUM_PINS | 3.3 V level selected |

## Verification
A guard that stays armed too long, or that accepts the wrong key, lets through a guarded write that should be dropped. The very next read of that register shows the change. The pin outputs show it in the cycle after the write edge, and `lock_err` stays low when it should have risen. A wrong field shift or width in the function or drive storage appears directly on `pin_func` or `pin_drv_ma` right after the write. A wrong read path appears in the registered read data one cycle after the request.

// File: rtl/pinmux_pkg.sv
// Package: shared constants, region type and address decode for the
// guarded pin configuration bank. Assumes 32-bit registers, byte offsets.
package pinmux_pkg;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int SLOT_W  = 4;
    localparam int CODE_W  = 3;
    localparam int MA_W    = 5;

    typedef enum logic [3:0] {
        RG_NONE, RG_UNLOCK, RG_MODE, RG_FUNC, RG_DRV,
        RG_PEN, RG_PDIR, RG_VSEL, RG_STAT
    } region_e;

    typedef struct packed {
        region_e    rg;
        logic [5:0] idx;
    } dec_t;

    // Map a byte offset to a region and register index; out of range -> RG_NONE.
    function automatic dec_t decode_addr(logic [ADDR_W-1:0] a, int bit_regs, int slot_regs);
        dec_t d;
        int   n;
        d.idx = a[7:2];
        d.rg  = RG_NONE;
        n     = int'(a[7:2]);
        if (a[1:0] == 2'b00) begin
            case (a[11:8])
                4'h0: if (a[7:0] == 8'h00) d.rg = RG_UNLOCK;
                4'h1: if (n < bit_regs)  d.rg = RG_MODE;
                4'h2: if (n < slot_regs) d.rg = RG_FUNC;
                4'h3: if (n < slot_regs) d.rg = RG_DRV;
                4'h4: if (n < bit_regs)  d.rg = RG_PEN;
                4'h5: if (n < bit_regs)  d.rg = RG_PDIR;
                4'h6: if (n < bit_regs)  d.rg = RG_VSEL;
                4'h7: if (a[7:0] == 8'h00) d.rg = RG_STAT;
                default: d.rg = RG_NONE;
            endcase
        end
        return d;
    endfunction

    // Guarded regions need a preceding complement key write.
    function automatic logic is_guarded(region_e r);
        return (r == RG_MODE) || (r == RG_FUNC) || (r == RG_DRV) || (r == RG_VSEL);
    endfunction
endpackage

// File: rtl/pinmux_unlock.sv
// Module: write guard. Holds the last unlock key and whether it is still
// armed, judges guarded writes and keeps the sticky error flag.
// Assumes at most one bus access per cycle.
module pinmux_unlock
    import pinmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  region_e           acc_rg,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              pass_o,
    output logic              armed_o,
    output logic              err_o
);
    logic              armed_q;
    logic [DATA_W-1:0] key_q;
    logic              err_q;

    // A guarded write passes only against the complement of the stored key.
    assign pass_o  = armed_q && (key_q == ~acc_wdata);
    assign armed_o = armed_q;
    assign err_o   = err_q;

    // Arm on an unlock write; any other access disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            key_q   <= '0;
        end else if (acc_en) begin
            if (acc_we && acc_rg == RG_UNLOCK) begin
                armed_q <= 1'b1;
                key_q   <= acc_wdata;
            end else begin
                armed_q <= 1'b0;
            end
        end
    end

    // Sticky error: set on a dropped guarded write, cleared by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (acc_en && acc_we) begin
            if (is_guarded(acc_rg) && !pass_o) err_q <= 1'b1;
            else if (acc_rg == RG_STAT)        err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pinmux_regs.sv
// Module: configuration storage and registered read path. Guarded regions
// are written only with pass_i high; drive slots keep only the code bits
// the pin owns (3 on even-mask pins, 2 otherwise).
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int                    NUM_PINS  = 64,
    parameter logic [NUM_PINS-1:0]   DRV3_MASK = {(NUM_PINS/2){2'b01}}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_en,
    input  logic                         acc_we,
    input  dec_t                         acc_dec,
    input  logic [DATA_W-1:0]            acc_wdata,
    input  logic                         pass_i,
    input  logic                         err_i,
    output logic [NUM_PINS-1:0]          mode_o,
    output logic [NUM_PINS*SLOT_W-1:0]   func_o,
    output logic [NUM_PINS*CODE_W-1:0]   drv_code_o,
    output logic [NUM_PINS-1:0]          pen_o,
    output logic [NUM_PINS-1:0]          pdir_o,
    output logic [NUM_PINS-1:0]          vsel_o,
    output logic [DATA_W-1:0]            rdata_o
);
    localparam int SLOT_BITS = NUM_PINS * SLOT_W;

    // Per-slot keep mask derived from the width of each pin's drive field.
    function automatic logic [SLOT_BITS-1:0] keep_mask();
        logic [SLOT_BITS-1:0] m;
        for (int p = 0; p < NUM_PINS; p++)
            m[p*SLOT_W +: SLOT_W] = DRV3_MASK[p] ? 4'b0111 : 4'b0011;
        return m;
    endfunction
    localparam logic [SLOT_BITS-1:0] DRV_KEEP = keep_mask();

    logic [NUM_PINS-1:0]  mode_q, pen_q, pdir_q, vsel_q;
    logic [SLOT_BITS-1:0] func_q, drv_q;
    logic [DATA_W-1:0]    rd_mux, rdata_q;
    logic                 wr_ok;
    int                   base;

    // A write lands when unguarded, or when the guard passed it.
    assign wr_ok = acc_en && acc_we && (!is_guarded(acc_dec.rg) || pass_i);
    assign base  = int'(acc_dec.idx) * DATA_W;

    // Register storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0; pen_q <= '0; pdir_q <= '0; vsel_q <= '0;
            func_q <= '0; drv_q <= '0;
        end else if (wr_ok) begin
            case (acc_dec.rg)
                RG_MODE: mode_q[base +: DATA_W] <= acc_wdata;
                RG_FUNC: func_q[base +: DATA_W] <= acc_wdata;
                RG_DRV:  drv_q[base +: DATA_W]  <= acc_wdata & DRV_KEEP[base +: DATA_W];
                RG_PEN:  pen_q[base +: DATA_W]  <= acc_wdata;
                RG_PDIR: pdir_q[base +: DATA_W] <= acc_wdata;
                RG_VSEL: vsel_q[base +: DATA_W] <= acc_wdata;
                default: ;
            endcase
        end
    end

    // Read data select; unmapped and unlock read zero.
    always_comb begin
        rd_mux = '0;
        case (acc_dec.rg)
            RG_MODE: rd_mux = mode_q[base +: DATA_W];
            RG_FUNC: rd_mux = func_q[base +: DATA_W];
            RG_DRV:  rd_mux = drv_q[base +: DATA_W];
            RG_PEN:  rd_mux = pen_q[base +: DATA_W];
            RG_PDIR: rd_mux = pdir_q[base +: DATA_W];
            RG_VSEL: rd_mux = vsel_q[base +: DATA_W];
            RG_STAT: rd_mux = {{(DATA_W-1){1'b0}}, err_i};
            default: rd_mux = '0;
        endcase
    end

    // Read data register, loaded on read requests only.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (acc_en && !acc_we) rdata_q <= rd_mux;
    end

    // Hand the low code bits of each drive slot to the decoder.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_code
        assign drv_code_o[p*CODE_W +: CODE_W] = drv_q[p*SLOT_W +: CODE_W];
    end

    assign mode_o  = mode_q;
    assign func_o  = func_q;
    assign pen_o   = pen_q;
    assign pdir_o  = pdir_q;
    assign vsel_o  = vsel_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/pinmux_decode.sv
// Module: per-pin decode of stored fields into pad controls. Pure
// combinational; function output gated by mode, drive scaled to mA.
module pinmux_decode
    import pinmux_pkg::*;
#(
    parameter int                  NUM_PINS  = 64,
    parameter logic [NUM_PINS-1:0] DRV3_MASK = {(NUM_PINS/2){2'b01}}
) (
    input  logic [NUM_PINS-1:0]        mode_i,
    input  logic [NUM_PINS*SLOT_W-1:0] func_i,
    input  logic [NUM_PINS*CODE_W-1:0] drv_code_i,
    input  logic [NUM_PINS-1:0]        pen_i,
    input  logic [NUM_PINS-1:0]        pdir_i,
    input  logic [NUM_PINS-1:0]        vsel_i,
    output logic [NUM_PINS-1:0]        periph_o,
    output logic [NUM_PINS*SLOT_W-1:0] func_o,
    output logic [NUM_PINS*MA_W-1:0]   drv_ma_o,
    output logic [NUM_PINS-1:0]        pull_up_o,
    output logic [NUM_PINS-1:0]        pull_dn_o,
    output logic [NUM_PINS-1:0]        v33_o
);
    localparam logic [MA_W-1:0] STEP3 = 5'd3;
    localparam logic [MA_W-1:0] STEP2 = 5'd6;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [MA_W-1:0] code_ext;
        // Widen the stored code and add one step.
        assign code_ext = {2'b00, drv_code_i[p*CODE_W +: CODE_W]} + 5'd1;
        // Function shown only in peripheral mode.
        assign func_o[p*SLOT_W +: SLOT_W] = mode_i[p] ? func_i[p*SLOT_W +: SLOT_W] : '0;
        if (DRV3_MASK[p]) begin : g_w3
            assign drv_ma_o[p*MA_W +: MA_W] = code_ext * STEP3;
        end else begin : g_w2
            assign drv_ma_o[p*MA_W +: MA_W] = code_ext * STEP2;
        end
    end

    assign periph_o  = mode_i;
    assign pull_up_o = pen_i & pdir_i;
    assign pull_dn_o = pen_i & ~pdir_i;
    assign v33_o     = vsel_i;
endmodule

// File: rtl/pinmux_ctrl.sv
// Module: top of the guarded pin configuration bank. Decodes the bus
// offset once and shares it between the guard and the storage; assumes
// NUM_PINS is a multiple of 32 and at most 256.
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int                  NUM_PINS  = 64,
    parameter logic [NUM_PINS-1:0] DRV3_MASK = {(NUM_PINS/2){2'b01}}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [11:0]                  bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         lock_err,
    output logic [NUM_PINS-1:0]          pin_periph,
    output logic [NUM_PINS*4-1:0]        pin_func,
    output logic [NUM_PINS*5-1:0]        pin_drv_ma,
    output logic [NUM_PINS-1:0]          pin_pull_up,
    output logic [NUM_PINS-1:0]          pin_pull_dn,
    output logic [NUM_PINS-1:0]          pin_v33
);
    localparam int BIT_REGS  = NUM_PINS / DATA_W;
    localparam int SLOT_REGS = NUM_PINS * SLOT_W / DATA_W;

    dec_t                         dec;
    logic                         guard_pass, guard_armed;
    logic [NUM_PINS-1:0]          mode_w, pen_w, pdir_w, vsel_w;
    logic [NUM_PINS*SLOT_W-1:0]   func_w;
    logic [NUM_PINS*CODE_W-1:0]   code_w;

    // Single offset decode shared by guard and storage.
    assign dec = decode_addr(bus_addr, BIT_REGS, SLOT_REGS);

    pinmux_unlock u_guard (
        .clk(clk), .rst_n(rst_n), .acc_en(bus_en), .acc_we(bus_we),
        .acc_rg(dec.rg), .acc_wdata(bus_wdata),
        .pass_o(guard_pass), .armed_o(guard_armed), .err_o(lock_err)
    );

    pinmux_regs #(.NUM_PINS(NUM_PINS), .DRV3_MASK(DRV3_MASK)) u_regs (
        .clk(clk), .rst_n(rst_n), .acc_en(bus_en), .acc_we(bus_we),
        .acc_dec(dec), .acc_wdata(bus_wdata), .pass_i(guard_pass), .err_i(lock_err),
        .mode_o(mode_w), .func_o(func_w), .drv_code_o(code_w),
        .pen_o(pen_w), .pdir_o(pdir_w), .vsel_o(vsel_w), .rdata_o(bus_rdata)
    );

    pinmux_decode #(.NUM_PINS(NUM_PINS), .DRV3_MASK(DRV3_MASK)) u_dec (
        .mode_i(mode_w), .func_i(func_w), .drv_code_i(code_w),
        .pen_i(pen_w), .pdir_i(pdir_w), .vsel_i(vsel_w),
        .periph_o(pin_periph), .func_o(pin_func), .drv_ma_o(pin_drv_ma),
        .pull_up_o(pin_pull_up), .pull_dn_o(pin_pull_dn), .v33_o(pin_v33)
    );
endmodule

// File: rtl/pinmux_ctrl_chk.sv
// Module: temporal checks on the guarded pin configuration bank, bound to
// every pinmux_ctrl instance. Observes ports and the guard's outputs.
module pinmux_ctrl_chk
    import pinmux_pkg::*;
#(
    parameter int NUM_PINS = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [11:0]         bus_addr,
    input logic [31:0]         bus_rdata,
    input logic                lock_err,
    input logic [NUM_PINS-1:0] pin_periph,
    input logic [NUM_PINS-1:0] pin_v33,
    input logic                guard_pass,
    input logic                guard_armed
);
    dec_t c_dec;
    assign c_dec = decode_addr(bus_addr, NUM_PINS / 32, NUM_PINS / 8);

    // R1: reset clears mode, voltage and error.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_periph == '0 && pin_v33 == '0 && !lock_err));

    // R2: without a bus write the mode outputs hold.
    assert_mode_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && bus_we) |=> $stable(pin_periph));

    // R3: a mode write refused by the guard leaves the mode outputs alone.
    assert_drop_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && c_dec.rg == RG_MODE && !guard_pass) |=> $stable(pin_periph));

    // R3: error flag is sticky until a status write.
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_err && !(bus_en && bus_we && c_dec.rg == RG_STAT)) |=> lock_err);

    // R5: any access but an unlock write leaves the guard disarmed.
    assert_disarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !(bus_we && c_dec.rg == RG_UNLOCK)) |=> !guard_armed);

    // R10: reads of unmapped offsets return zero one cycle later.
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && c_dec.rg == RG_NONE) |=> (bus_rdata == '0));
endmodule

bind pinmux_ctrl pinmux_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .lock_err(lock_err),
    .pin_periph(pin_periph), .pin_v33(pin_v33),
    .guard_pass(guard_pass), .guard_armed(guard_armed)
);

// File: tb/pinmux_ctrl_tb.sv
// Bench: reset checks, a table of bus operations walked by one loop,
// then directed checks on the pin outputs.
module pinmux_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;
    localparam int NV = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          lock_err;
    logic [NP-1:0] pin_periph, pin_pull_up, pin_pull_dn, pin_v33;
    logic [NP*4-1:0] pin_func;
    logic [NP*5-1:0] pin_drv_ma;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinmux_ctrl #(.NUM_PINS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lock_err(lock_err), .pin_periph(pin_periph), .pin_func(pin_func),
        .pin_drv_ma(pin_drv_ma), .pin_pull_up(pin_pull_up),
        .pin_pull_dn(pin_pull_dn), .pin_v33(pin_v33)
    );

    // Vector: {req[3:0], op[1:0] (0 write, 1 read-compare), addr[11:0], data[31:0]}
    localparam logic [49:0] VEC [NV] = '{
        {4'd2,  2'd0, 12'h000, ~32'h0000_0005},  // unlock for mode write
        {4'd2,  2'd0, 12'h100,  32'h0000_0005},  // R2 guarded write lands
        {4'd2,  2'd1, 12'h100,  32'h0000_0005},
        {4'd3,  2'd0, 12'h100,  32'hFFFF_FFFF},  // R3 no unlock: dropped
        {4'd3,  2'd1, 12'h100,  32'h0000_0005},
        {4'd11, 2'd1, 12'h700,  32'h0000_0001},  // R11 error visible
        {4'd11, 2'd0, 12'h700,  32'h0000_0000},  // clear
        {4'd11, 2'd1, 12'h700,  32'h0000_0000},
        {4'd5,  2'd0, 12'h000, ~32'h0000_00F0},  // arm
        {4'd8,  2'd0, 12'h400,  32'h0000_000F},  // R8 unguarded, disarms
        {4'd5,  2'd0, 12'h104,  32'h0000_00F0},  // R5 dropped
        {4'd5,  2'd1, 12'h104,  32'h0000_0000},
        {4'd8,  2'd1, 12'h400,  32'h0000_000F},
        {4'd4,  2'd0, 12'h000,  32'h1234_5678},  // wrong key
        {4'd4,  2'd0, 12'h200,  32'h0000_00A0},  // R4 dropped
        {4'd4,  2'd1, 12'h200,  32'h0000_0000},
        {4'd6,  2'd0, 12'h000, ~32'h0000_00A0},
        {4'd6,  2'd0, 12'h200,  32'h0000_00A0},  // R6 pin1 func = A
        {4'd12, 2'd0, 12'h200,  32'h0000_00B0},  // R12 second write dropped
        {4'd6,  2'd1, 12'h200,  32'h0000_00A0},
        {4'd7,  2'd0, 12'h000,  32'h0000_0000},
        {4'd7,  2'd0, 12'h300,  32'hFFFF_FFFF},  // R7 masked per pin width
        {4'd7,  2'd1, 12'h300,  32'h3737_3737},
        {4'd10, 2'd0, 12'h800,  32'hFFFF_FFFF},  // R10 unmapped write
        {4'd10, 2'd1, 12'h800,  32'h0000_0000},
        {4'd11, 2'd1, 12'h000,  32'h0000_0000},  // R11 unlock reads zero
        {4'd11, 2'd1, 12'h700,  32'h0000_0001},  // errors from R5/R4/R12 steps
        {4'd10, 2'd0, 12'h000, ~32'h0000_0001},
        {4'd10, 2'd0, 12'h108,  32'h0000_0001},  // beyond last mode register
        {4'd10, 2'd1, 12'h108,  32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive a write from one falling edge to the next.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    // Issue a read; data is registered at the edge, sampled at the next fall.
    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 periph", pin_periph[31:0], 32'h0);
        check("R1 func", pin_func[31:0], 32'h0);
        check("R1 pulls", {pin_pull_up[15:0], pin_pull_dn[15:0]}, 32'h0);
        check("R1 v33", pin_v33[31:0], 32'h0);
        check("R1 err", {31'b0, lock_err}, 32'h0);
        check("R1 drive pin0", {27'b0, pin_drv_ma[4:0]}, 32'd3);
        check("R1 drive pin1", {27'b0, pin_drv_ma[9:5]}, 32'd6);
        bus_read(12'h200, rd);
        check("R1 func reg", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][45:44] == 2'd0) begin
                bus_write(VEC[i][43:32], VEC[i][31:0]);
            end else begin
                bus_read(VEC[i][43:32], rd);
                check($sformatf("R%0d vec%0d", VEC[i][49:46], i), rd, VEC[i][31:0]);
            end
        end

        // R2 pins 0 and 2 peripheral
        check("R2 periph", pin_periph[31:0], 32'h0000_0005);
        // R3 sticky flag still set at the port
        check("R3 lock_err", {31'b0, lock_err}, 32'h1);
        // R6 pin1 holds function A but is GPIO -> 0; pin0 periph func 0
        check("R6 gpio gating", {28'b0, pin_func[7:4]}, 32'h0);
        bus_write(12'h000, ~32'h0000_0007);
        bus_write(12'h100, 32'h0000_0007);
        check("R6 periph func", {28'b0, pin_func[7:4]}, 32'hA);
        // R7 drive: full codes 24 mA, untouched pins minimum step
        check("R7 pin0 max", {27'b0, pin_drv_ma[4:0]}, 32'd24);
        check("R7 pin1 max", {27'b0, pin_drv_ma[9:5]}, 32'd24);
        check("R7 pin8 min", {27'b0, pin_drv_ma[44:40]}, 32'd3);
        check("R7 pin9 min", {27'b0, pin_drv_ma[49:45]}, 32'd6);
        bus_write(12'h000, ~32'h0000_0012);
        bus_write(12'h300, 32'h0000_0012);   // pin0 code 2 -> 9, pin1 code 1 -> 12
        check("R7 pin0 mid", {27'b0, pin_drv_ma[4:0]}, 32'd9);
        check("R7 pin1 mid", {27'b0, pin_drv_ma[9:5]}, 32'd12);
        // R8 pull direction
        check("R8 down only", {pin_pull_up[15:0], pin_pull_dn[15:0]}, 32'h0000_000F);
        bus_write(12'h500, 32'h0000_0005);
        check("R8 mixed", {pin_pull_up[15:0], pin_pull_dn[15:0]}, 32'h0005_000A);
        // R9 voltage guarded
        bus_write(12'h000, ~32'h0000_0001);
        bus_write(12'h600, 32'h0000_0001);
        check("R9 v33 set", pin_v33[31:0], 32'h1);
        bus_write(12'h604, 32'h0000_0001);
        check("R9 v33 guarded", pin_v33[63:32], 32'h0);
        // R1 reset again clears everything written
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset", {pin_periph[15:0], 15'b0, lock_err}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule